// File: doc/BRIEF.md
# Serial Command Decoder for a Dual Output Controller

This block is the serial command front end of a controller that drives two outputs. A host sends 8-bit command words, most significant bit first, while chip select is held low. The decoder runs on the local system clock. It oversamples the serial clock, chip select and data pins through synchronizers and acts on the edges it detects. A frame is acted on only when chip select rises after a non-zero whole number of bytes. The last complete byte is then decoded. Bits 6:4 are a register address. Bits 3:0 are the payload. Bit 7 selects the output channel for the per-output registers.

Bit 7 is also the watchdog bit. The host must flip it from one accepted frame to the next. If it stays the same for too long, the block raises a timeout and forces both outputs off until a frame arrives with a flipped bit 7. While chip select is low, the serial output first returns a status byte. The selector written by an earlier frame chooses its content. After that byte, the serial output repeats the bytes received earlier in the same frame, so several devices can be chained.

Top module: `spi_cmd_decoder`

## Requirements
- R1: Data is sampled on rising serial clock edges while chip select is low, MSB first. When chip select rises after N*8 bits (N >= 1), only the last 8 bits received are decoded and committed.
- R2: A frame of zero bits, or of a bit count that is not a multiple of 8, changes no register and does not count as a watchdog toggle.
- R3: Address 001 writes the output control bits: D3 = sense enable of output 1, D2 = on command of output 1, D1 = sense enable of output 0, D0 = on command of output 0. D7 has no effect here.
- R4: Addresses 010 (limit), 011 (detect) and 100 (input) each write a 4-bit configuration from D3:D0 into the output chosen by D7 (0 = output 0, 1 = output 1). The ports `limit_cfg`, `detect_cfg` and `input_cfg` carry output 1 in bits 7:4 and output 0 in bits 3:0.
- R5: Address 101 with D7 = 1 loads the watchdog period select from D1:D0. Address 101 with D7 = 0 loads the 3-bit delay setting from D2:D0.
- R6: Address 110 changes no register. Address 111 with D7 = 1 loads undervoltage disable from D1 and overvoltage disable from D0. Address 111 with D7 = 0 changes no register.
- R7: Address 000 loads the 3-bit status selector from D2:D0. D3 is ignored.
- R8: The first byte shifted out in a frame is {sel[2:0], payload[4:0]}. `sel` is the selector value when chip select falls. The payload is chosen by `sel`: 000 gives {timeout, |fault1, |fault0, uv_dis, ov_dis}; 001 gives {0, D3..D0 of the control register}; 010 and 011 give {0, limit cfg of output 0 and output 1}; 100 and 101 give {0, detect cfg of output 0 and output 1}; 110 and 111 give {0, fault0} and {0, fault1}. Each bit changes after a falling serial clock edge and is valid at the next rising edge.
- R9: In a multi-byte frame, byte k (k >= 1) shifted out equals byte k-1 received in the same frame.
- R10: An accepted frame counts as a watchdog toggle when its D7 differs from the D7 of the previous accepted frame, or when it is the first accepted frame since reset. A toggle clears the timeout. An accepted frame with an unchanged D7 does not clear it.
- R11: If no toggle occurs for WD_BASE << period_select clock cycles, `wd_expired` rises and `out_on` is forced to 00. The control register keeps its value.
- R12: Active-low reset clears every configuration register, the watchdog history and the timeout, and loads the status selector with 000. The serial output is 0 whenever chip select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | Serial clock from host, idle low |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_mosi | input | 1 | Serial command data in |
| spi_miso | output | 1 | Serial status / pass-through data out |
| fault0 | input | 4 | Fault flags of output 0 |
| fault1 | input | 4 | Fault flags of output 1 |
| out_on | output | 2 | Effective on command per output, gated by the watchdog |
| sense_en | output | 2 | Current-sense enable per output |
| limit_cfg | output | 8 | Limit configuration, {out1, out0} |
| detect_cfg | output | 8 | Detection configuration, {out1, out0} |
| input_cfg | output | 8 | Input configuration, {out1, out0} |
| delay_cfg | output | 3 | Delay setting |
| wd_sel | output | 2 | Watchdog period select |
| uv_dis | output | 1 | Undervoltage protection disable |
| ov_dis | output | 1 | Overvoltage protection disable |
| wd_expired | output | 1 | Watchdog timeout flag |

## Verification
Each pin goes through two synchronizer flops and one edge-detect flop. A rising chip select is therefore seen on the third clock, and the configuration outputs change on the fourth. The bench waits twelve clocks after raising chip select before it compares them with its model. The serial output changes about four clocks after each falling serial clock edge. The monitor samples it at the following rising edge, eight clocks later, and pops the expected byte that the driver pushed when the frame was planned. The watchdog is checked well clear of its window: it is read a few hundred clocks after a toggle when expecting no timeout, and more than the full period later when expecting one.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;

  localparam int CMD_W  = 8;
  localparam int CFG_W  = 4;
  localparam int N_OUT  = 2;
  localparam int SEL_W  = 3;

  typedef enum logic [2:0] {
    A_STAT   = 3'b000,
    A_CTRL   = 3'b001,
    A_LIMIT  = 3'b010,
    A_DETECT = 3'b011,
    A_INPUT  = 3'b100,
    A_TIMING = 3'b101,
    A_IDLE   = 3'b110,
    A_SUPPLY = 3'b111
  } reg_addr_e;

  typedef struct packed {
    logic              chan;
    reg_addr_e         addr;
    logic [CFG_W-1:0]  data;
  } cmd_t;

  // Watchdog window length in clock cycles for a given period select.
  function automatic int unsigned wd_span(input int unsigned base, input logic [1:0] sel);
    return base << sel;
  endfunction

  // Status byte returned first in every frame: selector echo plus payload.
  function automatic logic [CMD_W-1:0] status_word(
    input logic [SEL_W-1:0] sel,
    input logic             wd_exp,
    input logic [CFG_W-1:0] flt0,
    input logic [CFG_W-1:0] flt1,
    input logic [CFG_W-1:0] ctrl,
    input logic [CFG_W-1:0] lim0,
    input logic [CFG_W-1:0] lim1,
    input logic [CFG_W-1:0] det0,
    input logic [CFG_W-1:0] det1,
    input logic             uv,
    input logic             ov
  );
    logic [4:0] pay;
    case (sel)
      3'd0:    pay = {wd_exp, |flt1, |flt0, uv, ov};
      3'd1:    pay = {1'b0, ctrl};
      3'd2:    pay = {1'b0, lim0};
      3'd3:    pay = {1'b0, lim1};
      3'd4:    pay = {1'b0, det0};
      3'd5:    pay = {1'b0, det1};
      3'd6:    pay = {1'b0, flt0};
      default: pay = {1'b0, flt1};
    endcase
    return {sel, pay};
  endfunction

endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
  parameter int          STAGES    = 2,
  parameter int          N         = 3,
  parameter logic [N-1:0] RESET_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pin_raw,
  output logic [N-1:0] level,
  output logic [N-1:0] rise,
  output logic [N-1:0] fall
);

  for (genvar i = 0; i < N; i++) begin : g_pin
    logic [STAGES-1:0] chain;
    logic              prev;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        chain <= {STAGES{RESET_VAL[i]}};
        prev  <= RESET_VAL[i];
      end else begin
        chain <= {chain[STAGES-2:0], pin_raw[i]};
        prev  <= chain[STAGES-1];
      end
    end

    assign level[i] = chain[STAGES-1];
    assign rise[i]  = chain[STAGES-1] & ~prev;
    assign fall[i]  = ~chain[STAGES-1] & prev;
  end

endmodule

// File: rtl/spi_frame_shifter.sv
module spi_frame_shifter
  import spi_cmd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_frame,
  input  logic             frame_start,
  input  logic             frame_end,
  input  logic             sclk_rise,
  input  logic             sclk_fall,
  input  logic             mosi_s,
  input  logic [CMD_W-1:0] status_in,
  output logic             miso,
  output logic             commit,
  output logic [CMD_W-1:0] word
);

  localparam int PH_W = $clog2(CMD_W);

  logic [CMD_W-1:0] rx_q;
  logic [CMD_W-1:0] tx_q;
  logic             samp_q;
  logic [PH_W-1:0]  phase_q;
  logic             any_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_q    <= '0;
      tx_q    <= '0;
      samp_q  <= 1'b0;
      phase_q <= '0;
      any_q   <= 1'b0;
    end else if (frame_start) begin
      tx_q    <= status_in;
      phase_q <= '0;
      any_q   <= 1'b0;
    end else if (in_frame) begin
      if (sclk_rise) begin
        rx_q    <= {rx_q[CMD_W-2:0], mosi_s};
        samp_q  <= mosi_s;
        phase_q <= (phase_q == PH_W'(CMD_W-1)) ? '0 : phase_q + 1'b1;
        any_q   <= 1'b1;
      end
      if (sclk_fall) begin
        tx_q <= {tx_q[CMD_W-2:0], samp_q};
      end
    end
  end

  assign commit = frame_end && any_q && (phase_q == '0);
  assign word   = rx_q;
  assign miso   = in_frame ? tx_q[CMD_W-1] : 1'b0;

endmodule

// File: rtl/spi_cmd_regs.sv
module spi_cmd_regs
  import spi_cmd_pkg::*;
#(
  parameter logic [SEL_W-1:0] STAT_DEFAULT = 3'b000
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        commit,
  input  cmd_t                        cmd,
  output logic [SEL_W-1:0]            stat_sel,
  output logic [CFG_W-1:0]            ctrl_q,
  output logic [N_OUT-1:0][CFG_W-1:0] lim_q,
  output logic [N_OUT-1:0][CFG_W-1:0] det_q,
  output logic [N_OUT-1:0][CFG_W-1:0] inp_q,
  output logic [2:0]                  dly_q,
  output logic [1:0]                  wdsel_q,
  output logic                        uv_q,
  output logic                        ov_q
);

  // Per-output configuration registers, steered by the channel bit.
  for (genvar ch = 0; ch < N_OUT; ch++) begin : g_out
    logic hit;
    assign hit = commit && (cmd.chan == 1'(ch));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lim_q[ch] <= '0;
        det_q[ch] <= '0;
        inp_q[ch] <= '0;
      end else if (hit) begin
        if (cmd.addr == A_LIMIT)  lim_q[ch] <= cmd.data;
        if (cmd.addr == A_DETECT) det_q[ch] <= cmd.data;
        if (cmd.addr == A_INPUT)  inp_q[ch] <= cmd.data;
      end
    end
  end

  // Shared registers.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_sel <= STAT_DEFAULT;
      ctrl_q   <= '0;
      dly_q    <= '0;
      wdsel_q  <= '0;
      uv_q     <= 1'b0;
      ov_q     <= 1'b0;
    end else if (commit) begin
      case (cmd.addr)
        A_STAT:   stat_sel <= cmd.data[SEL_W-1:0];
        A_CTRL:   ctrl_q   <= cmd.data;
        A_TIMING: begin
          if (cmd.chan) wdsel_q <= cmd.data[1:0];
          else          dly_q   <= cmd.data[2:0];
        end
        A_SUPPLY: begin
          if (cmd.chan) begin
            uv_q <= cmd.data[1];
            ov_q <= cmd.data[0];
          end
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/spi_wdog.sv
module spi_wdog
  import spi_cmd_pkg::*;
#(
  parameter int unsigned WD_BASE = 1024,
  parameter int          CNT_W   = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             commit,
  input  logic             d7,
  input  logic [1:0]       sel,
  output logic             toggle,
  output logic             expired,
  output logic [CNT_W-1:0] cnt
);

  logic             hist_v;
  logic             last_d7;
  logic [CNT_W-1:0] limit;

  assign limit  = CNT_W'(wd_span(WD_BASE, sel));
  assign toggle = commit && (!hist_v || (d7 != last_d7));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_v  <= 1'b0;
      last_d7 <= 1'b0;
    end else if (commit) begin
      hist_v  <= 1'b1;
      last_d7 <= d7;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      expired <= 1'b0;
    end else if (toggle) begin
      cnt     <= '0;
      expired <= 1'b0;
    end else if (!expired) begin
      if (cnt >= limit - 1'b1) expired <= 1'b1;
      else                     cnt     <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/spi_cmd_decoder.sv
module spi_cmd_decoder
  import spi_cmd_pkg::*;
#(
  parameter int          SYNC_STAGES  = 2,
  parameter int unsigned WD_BASE      = 1024,
  parameter logic [2:0]  STAT_DEFAULT = 3'b000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       spi_sclk,
  input  logic       spi_cs_n,
  input  logic       spi_mosi,
  output logic       spi_miso,
  input  logic [3:0] fault0,
  input  logic [3:0] fault1,
  output logic [1:0] out_on,
  output logic [1:0] sense_en,
  output logic [7:0] limit_cfg,
  output logic [7:0] detect_cfg,
  output logic [7:0] input_cfg,
  output logic [2:0] delay_cfg,
  output logic [1:0] wd_sel,
  output logic       uv_dis,
  output logic       ov_dis,
  output logic       wd_expired
);

  localparam int WD_CNT_W = $clog2(WD_BASE) + 4;

  // Pin index: 0 = chip select, 1 = serial clock, 2 = data in.
  logic [2:0] pin_lvl, pin_rise, pin_fall;

  spi_pin_sync #(
    .STAGES    (SYNC_STAGES),
    .N         (3),
    .RESET_VAL (3'b001)
  ) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .pin_raw ({spi_mosi, spi_sclk, spi_cs_n}),
    .level   (pin_lvl),
    .rise    (pin_rise),
    .fall    (pin_fall)
  );

  logic                        in_frame;
  logic                        cmd_commit;
  logic [CMD_W-1:0]            cmd_word;
  logic [CMD_W-1:0]            stat_byte;
  logic [SEL_W-1:0]            stat_sel;
  logic [CFG_W-1:0]            ctrl_q;
  logic [N_OUT-1:0][CFG_W-1:0] lim_q, det_q, inp_q;
  logic                        wd_toggle;
  logic                        wd_exp;
  logic [WD_CNT_W-1:0]         wd_cnt;
  cmd_t                        cmd;

  assign in_frame = ~pin_lvl[0];
  assign cmd      = cmd_t'(cmd_word);

  spi_frame_shifter u_shift (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_frame    (in_frame),
    .frame_start (pin_fall[0]),
    .frame_end   (pin_rise[0]),
    .sclk_rise   (pin_rise[1]),
    .sclk_fall   (pin_fall[1]),
    .mosi_s      (pin_lvl[2]),
    .status_in   (stat_byte),
    .miso        (spi_miso),
    .commit      (cmd_commit),
    .word        (cmd_word)
  );

  spi_cmd_regs #(
    .STAT_DEFAULT (STAT_DEFAULT)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .commit   (cmd_commit),
    .cmd      (cmd),
    .stat_sel (stat_sel),
    .ctrl_q   (ctrl_q),
    .lim_q    (lim_q),
    .det_q    (det_q),
    .inp_q    (inp_q),
    .dly_q    (delay_cfg),
    .wdsel_q  (wd_sel),
    .uv_q     (uv_dis),
    .ov_q     (ov_dis)
  );

  spi_wdog #(
    .WD_BASE (WD_BASE),
    .CNT_W   (WD_CNT_W)
  ) u_wdog (
    .clk     (clk),
    .rst_n   (rst_n),
    .commit  (cmd_commit),
    .d7      (cmd.chan),
    .sel     (wd_sel),
    .toggle  (wd_toggle),
    .expired (wd_exp),
    .cnt     (wd_cnt)
  );

  assign stat_byte  = status_word(stat_sel, wd_exp, fault0, fault1, ctrl_q,
                                  lim_q[0], lim_q[1], det_q[0], det_q[1],
                                  uv_dis, ov_dis);

  assign sense_en   = {ctrl_q[3], ctrl_q[1]};
  assign out_on     = {ctrl_q[2], ctrl_q[0]} & ~{2{wd_exp}};
  assign limit_cfg  = lim_q;
  assign detect_cfg = det_q;
  assign input_cfg  = inp_q;
  assign wd_expired = wd_exp;

endmodule

// File: rtl/spi_cmd_decoder_checker.sv
module spi_cmd_decoder_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_commit,
  input logic [7:0] cmd_word,
  input logic       wd_toggle,
  input logic       wd_expired,
  input logic [1:0] out_on,
  input logic [1:0] sense_en,
  input logic [7:0] limit_cfg,
  input logic [7:0] detect_cfg,
  input logic [7:0] input_cfg,
  input logic [2:0] delay_cfg,
  input logic [1:0] wd_sel,
  input logic       uv_dis,
  input logic       ov_dis
);

  logic [33:0] cfg_bus;
  assign cfg_bus = {sense_en, limit_cfg, detect_cfg, input_cfg, delay_cfg, wd_sel, uv_dis, ov_dis};

  a_r1_commit_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_commit |=> !cmd_commit);

  a_r2_regs_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_commit |=> $stable(cfg_bus));

  a_r3_ctrl_write: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_commit && cmd_word[6:4] == 3'b001) |=>
      (sense_en == {$past(cmd_word[3]), $past(cmd_word[1])}));

  a_r5_wdsel_write: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_commit && cmd_word[7:4] == 4'b1101) |=> (wd_sel == $past(cmd_word[1:0])));

  a_r10_toggle_clears: assert property (@(posedge clk) disable iff (!rst_n)
    wd_toggle |=> !wd_expired);

  a_r11_forced_off: assert property (@(posedge clk) disable iff (!rst_n)
    wd_expired |-> (out_on == 2'b00));

endmodule

bind spi_cmd_decoder spi_cmd_decoder_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cmd_commit (cmd_commit),
  .cmd_word   (cmd_word),
  .wd_toggle  (wd_toggle),
  .wd_expired (wd_expired),
  .out_on     (out_on),
  .sense_en   (sense_en),
  .limit_cfg  (limit_cfg),
  .detect_cfg (detect_cfg),
  .input_cfg  (input_cfg),
  .delay_cfg  (delay_cfg),
  .wd_sel     (wd_sel),
  .uv_dis     (uv_dis),
  .ov_dis     (ov_dis)
);

// File: tb/spi_cmd_decoder_test.sv
`timescale 1ns/1ps
module spi_cmd_decoder_test;

  localparam int HALF = 8;  // system clocks per serial half period

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       spi_sclk = 1'b0;
  logic       spi_cs_n = 1'b1;
  logic       spi_mosi = 1'b0;
  logic       spi_miso;
  logic [3:0] fault0 = 4'b0010;
  logic [3:0] fault1 = 4'b0000;
  logic [1:0] out_on, sense_en, wd_sel;
  logic [7:0] limit_cfg, detect_cfg, input_cfg;
  logic [2:0] delay_cfg;
  logic       uv_dis, ov_dis, wd_expired;

  always #2 clk = ~clk;

  spi_cmd_decoder uut (
    .clk(clk), .rst_n(rst_n), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .fault0(fault0), .fault1(fault1),
    .out_on(out_on), .sense_en(sense_en), .limit_cfg(limit_cfg),
    .detect_cfg(detect_cfg), .input_cfg(input_cfg), .delay_cfg(delay_cfg),
    .wd_sel(wd_sel), .uv_dis(uv_dis), .ov_dis(ov_dis), .wd_expired(wd_expired)
  );

  int n_chk = 0;
  int n_bad = 0;

  // Reference model state
  logic [3:0] m_ctrl = '0;
  logic [3:0] m_lim [2] = '{default: '0};
  logic [3:0] m_det [2] = '{default: '0};
  logic [3:0] m_inp [2] = '{default: '0};
  logic [2:0] m_dly = '0, m_sel = '0;
  logic [1:0] m_wd = '0;
  logic       m_uv = 0, m_ov = 0, m_exp = 0, m_hv = 0, m_last = 0;

  logic [7:0] exp_q [$];
  string      req_q [$];

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] model_status();
    logic [4:0] p;
    case (m_sel)
      3'd0: p = {m_exp, fault1 != 0, fault0 != 0, m_uv, m_ov};
      3'd1: p = {1'b0, m_ctrl};
      3'd2: p = {1'b0, m_lim[0]};
      3'd3: p = {1'b0, m_lim[1]};
      3'd4: p = {1'b0, m_det[0]};
      3'd5: p = {1'b0, m_det[1]};
      3'd6: p = {1'b0, fault0};
      default: p = {1'b0, fault1};
    endcase
    return {m_sel, p};
  endfunction

  task automatic model_apply(input logic [7:0] w);
    logic c;
    c = w[7];
    if (!m_hv || c != m_last) m_exp = 0;
    m_hv = 1;
    m_last = c;
    case (w[6:4])
      3'b000: m_sel = w[2:0];
      3'b001: m_ctrl = w[3:0];
      3'b010: m_lim[c] = w[3:0];
      3'b011: m_det[c] = w[3:0];
      3'b100: m_inp[c] = w[3:0];
      3'b101: if (c) m_wd = w[1:0]; else m_dly = w[2:0];
      3'b111: if (c) begin m_uv = w[1]; m_ov = w[0]; end
      default: ;
    endcase
  endtask

  task automatic check_regs(input string req);
    check({req, " out_on"},     {30'd0, out_on},   {30'd0, (m_exp ? 2'b00 : {m_ctrl[2], m_ctrl[0]})});
    check({req, " sense_en"},   {30'd0, sense_en}, {30'd0, m_ctrl[3], m_ctrl[1]});
    check({req, " limit_cfg"},  {24'd0, limit_cfg},  {24'd0, m_lim[1], m_lim[0]});
    check({req, " detect_cfg"}, {24'd0, detect_cfg}, {24'd0, m_det[1], m_det[0]});
    check({req, " input_cfg"},  {24'd0, input_cfg},  {24'd0, m_inp[1], m_inp[0]});
    check({req, " misc"}, {25'd0, delay_cfg, wd_sel, uv_dis, ov_dis},
                          {25'd0, m_dly, m_wd, m_uv, m_ov});
    check({req, " wd_expired"}, {31'd0, wd_expired}, {31'd0, m_exp});
  endtask

  // Driver: plans the expected serial output, then shifts the frame.
  task automatic spi_xfer(input string req, input logic [7:0] a, input logic [7:0] b,
                          input logic [7:0] c, input int nbits);
    logic [7:0] ws [3];
    int nw;
    ws[0] = a; ws[1] = b; ws[2] = c;
    nw = nbits / 8;
    for (int k = 0; k < nw; k++) begin
      exp_q.push_back(k == 0 ? model_status() : ws[k-1]);
      req_q.push_back(k == 0 ? {req, " R8 status"} : {req, " R9 pass"});
    end
    @(negedge clk);
    spi_cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      spi_mosi = ws[i/8][7 - (i % 8)];
      repeat (HALF) @(negedge clk);
      spi_sclk = 1'b1;
      repeat (HALF) @(negedge clk);
      spi_sclk = 1'b0;
    end
    repeat (HALF) @(negedge clk);
    spi_cs_n = 1'b1;
    repeat (12) @(negedge clk);
    if (nbits > 0 && nbits % 8 == 0) model_apply(ws[nw-1]);
  endtask

  // Monitor: collects serial output bytes and compares with the queue.
  int         mcnt = 0;
  logic [7:0] mbyte = '0;
  always @(negedge spi_cs_n) mcnt = 0;
  always @(posedge spi_sclk) begin
    if (!spi_cs_n) begin
      mbyte = {mbyte[6:0], spi_miso};
      mcnt++;
      if (mcnt == 8) begin
        mcnt = 0;
        if (exp_q.size() == 0) check("R8 unexpected byte", {24'd0, mbyte}, 32'hffff_ffff);
        else check(req_q.pop_front(), {24'd0, mbyte}, {24'd0, exp_q.pop_front()});
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check_regs("R12 reset");
    check("R12 miso idle", {31'd0, spi_miso}, 32'd0);

    spi_xfer("R5", 8'hD3, 8'h00, 8'h00, 8);   // wd period 3, first toggle
    check_regs("R5 wd select");
    spi_xfer("R3", 8'h1A, 8'h00, 8'h00, 8);
    check_regs("R3 sense only");
    spi_xfer("R3", 8'h95, 8'h00, 8'h00, 8);   // D7 set, ignored by control
    check_regs("R3 d7 ignored");
    spi_xfer("R4", 8'h29, 8'h00, 8'h00, 8);
    spi_xfer("R4", 8'hA6, 8'h00, 8'h00, 8);
    spi_xfer("R4", 8'h33, 8'h00, 8'h00, 8);
    spi_xfer("R4", 8'hBC, 8'h00, 8'h00, 8);
    spi_xfer("R4", 8'h45, 8'h00, 8'h00, 8);
    spi_xfer("R4", 8'hCE, 8'h00, 8'h00, 8);
    check_regs("R4 per-output cfg");
    spi_xfer("R5", 8'h56, 8'h00, 8'h00, 8);
    check_regs("R5 delay");
    spi_xfer("R6", 8'hEF, 8'h00, 8'h00, 8);
    spi_xfer("R6", 8'h6F, 8'h00, 8'h00, 8);
    check_regs("R6 no action");
    spi_xfer("R6", 8'hF3, 8'h00, 8'h00, 8);
    spi_xfer("R6", 8'h70, 8'h00, 8'h00, 8);
    check_regs("R6 supply");
    spi_xfer("R7", 8'h0A, 8'h00, 8'h00, 8);   // selector 010, D3 ignored
    check({"R7 selector"}, {24'd0, model_status()}, 32'h49);
    spi_xfer("R1", 8'h2F, 8'hB7, 8'h07, 24);  // only last byte commits
    check_regs("R1 last byte only");
    fault1 = 4'b1000;
    spi_xfer("R2", 8'h95, 8'hF0, 8'h00, 12);
    spi_xfer("R2", 8'h1F, 8'h00, 8'h00, 5);
    spi_xfer("R2", 8'h00, 8'h00, 8'h00, 0);
    check_regs("R2 partial ignored");
    spi_xfer("R8", 8'h80, 8'h00, 8'h00, 8);   // selector 000
    spi_xfer("R11", 8'hD0, 8'h00, 8'h00, 8);  // wd period 0, no toggle
    repeat (1200) @(negedge clk);
    m_exp = 1;
    check_regs("R11 expired");
    spi_xfer("R10", 8'h95, 8'h00, 8'h00, 8);  // same D7: stays expired
    check_regs("R10 no toggle");
    spi_xfer("R10", 8'h15, 8'h00, 8'h00, 8);  // flipped D7 clears
    check_regs("R10 toggle clears");
    check("R9 queue drained", exp_q.size(), 32'd0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule